// File: doc/BRIEF.md
# Sequential Integer Square Root

This unit computes the integer square root of an unsigned radicand, one root bit per clock. A request is accepted when `start_i` is high while the unit is idle. The radicand is then captured and `busy_o` rises. The root is built from its top bit downward. For each bit, the bit is set in a trial value and the trial is squared. The square is compared with the radicand. The bit stays set only when the square does not exceed the radicand.

A single squarer and comparator serve every iteration. A running copy of the accepted square gives the remainder without a second multiplier. After the last bit, `valid_o` pulses for one cycle. At that pulse the root and the remainder (radicand minus root squared) are presented. Both outputs then hold until the next operation completes. The width is set by one parameter, and the root takes half of it.

Top module: `isqrt_seq`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first result, `busy_o` and `valid_o` are 0 and `root_o` and `rem_o` are 0.
- R2: When `start_i` is high at a clock edge while `busy_o` is low, the radicand on `radicand_i` is captured and `busy_o` is high after that edge.
- R3: `start_i` and `radicand_i` presented while `busy_o` is high are ignored. The result belongs to the captured radicand, and no second result follows.
- R4: `valid_o` rises exactly WIDTH/2 clock edges after the capture edge and stays high for exactly one cycle. `busy_o` falls on the same edge on which `valid_o` rises.
- R5: At `valid_o`, `root_o` is the largest value r with r*r <= radicand, so that r*r <= x < (r+1)*(r+1).
- R6: At `valid_o`, `rem_o` (WIDTH/2+1 bits) equals the radicand minus `root_o` squared.
- R7: Between results, `root_o` and `rem_o` keep their last values, whatever is driven on `radicand_i`.
- R8: A radicand of 0 gives root 0 and remainder 0. At WIDTH 8, a radicand of 255 gives root 15 and remainder 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; taken only while idle |
| radicand_i | input | WIDTH | Unsigned operand |
| busy_o | output | 1 | Operation in progress |
| valid_o | output | 1 | One-cycle result strobe |
| root_o | output | WIDTH/2 | Integer square root |
| rem_o | output | WIDTH/2+1 | Radicand minus root squared |

## Verification
The bench builds the unit at the default WIDTH of 8. At that width every one of the 256 radicands can be swept exhaustively, along with both extremes 0 and 255. A four-cycle iteration also leaves room to inject an ignored request in the middle of an operation. Seeded random operands then repeat the sweep pattern with such mid-operation requests, and with idle gaps that exercise output holding.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  // bits needed to index the root bits, never zero
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/isqrt_sq_cmp.sv
module isqrt_sq_cmp #(
  parameter int WIDTH  = 8,
  parameter int ROOT_W = WIDTH / 2
) (
  input  logic [ROOT_W-1:0] trial_i,
  input  logic [WIDTH-1:0]  radicand_i,
  output logic [WIDTH-1:0]  square_o,
  output logic              keep_o
);
  always_comb begin
    square_o = WIDTH'(trial_i) * WIDTH'(trial_i);
    keep_o   = square_o <= radicand_i;
  end
endmodule

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl #(
  parameter int ROOT_W = 4,
  parameter int IDX_W  = isqrt_pkg::idx_bits(ROOT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             valid_o
);
  logic             busy_q, valid_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o  = start_i && !busy_q;
  assign step_o  = busy_q;
  assign last_o  = (idx_q == '0);
  assign idx_o   = idx_q;
  assign busy_o  = busy_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= busy_q && last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        idx_q  <= IDX_W'(ROOT_W - 1);
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        idx_q  <= idx_q - IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/isqrt_datapath.sv
module isqrt_datapath #(
  parameter int WIDTH  = 8,
  parameter int ROOT_W = WIDTH / 2,
  parameter int REM_W  = ROOT_W + 1,
  parameter int IDX_W  = isqrt_pkg::idx_bits(ROOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WIDTH-1:0]  radicand_i,
  output logic [ROOT_W-1:0] root_o,
  output logic [REM_W-1:0]  rem_o
);
  logic [WIDTH-1:0]  rad_q, conf_sq_q, square, sq_nxt;
  logic [ROOT_W-1:0] trial_q, conf_q, conf_nxt, next_bit, root_q;
  logic [REM_W-1:0]  rem_q;
  logic              keep;

  isqrt_sq_cmp #(.WIDTH(WIDTH), .ROOT_W(ROOT_W)) u_cmp (
    .trial_i    (trial_q),
    .radicand_i (rad_q),
    .square_o   (square),
    .keep_o     (keep)
  );

  always_comb begin
    conf_nxt = keep ? trial_q : conf_q;
    // square of the confirmed value, tracked instead of recomputed
    sq_nxt   = keep ? square : conf_sq_q;
    next_bit = ROOT_W'(1) << (idx_i - IDX_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rad_q     <= '0;
      trial_q   <= '0;
      conf_q    <= '0;
      conf_sq_q <= '0;
      root_q    <= '0;
      rem_q     <= '0;
    end else if (load_i) begin
      rad_q     <= radicand_i;
      trial_q   <= ROOT_W'(1) << (ROOT_W - 1);
      conf_q    <= '0;
      conf_sq_q <= '0;
    end else if (step_i) begin
      conf_q    <= conf_nxt;
      conf_sq_q <= sq_nxt;
      if (last_i) begin
        root_q <= conf_nxt;
        rem_q  <= REM_W'(rad_q - sq_nxt);
      end else begin
        trial_q <= conf_nxt | next_bit;
      end
    end
  end

  assign root_o = root_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/isqrt_seq.sv
module isqrt_seq #(
  parameter int WIDTH = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [WIDTH-1:0]       radicand_i,
  output logic                   busy_o,
  output logic                   valid_o,
  output logic [WIDTH/2-1:0]     root_o,
  output logic [WIDTH/2:0]       rem_o
);
  localparam int ROOT_W = WIDTH / 2;
  localparam int REM_W  = ROOT_W + 1;
  localparam int IDX_W  = isqrt_pkg::idx_bits(ROOT_W);

  logic             load, step, last;
  logic [IDX_W-1:0] idx;

  isqrt_ctrl #(.ROOT_W(ROOT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .idx_o   (idx),
    .busy_o  (busy_o),
    .valid_o (valid_o)
  );

  isqrt_datapath #(.WIDTH(WIDTH), .ROOT_W(ROOT_W), .REM_W(REM_W), .IDX_W(IDX_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .last_i     (last),
    .idx_i      (idx),
    .radicand_i (radicand_i),
    .root_o     (root_o),
    .rem_o      (rem_o)
  );
endmodule

// File: rtl/isqrt_seq_chk.sv
module isqrt_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [WIDTH-1:0]   radicand_i,
  input logic               busy_o,
  input logic               valid_o,
  input logic [WIDTH/2-1:0] root_o,
  input logic [WIDTH/2:0]   rem_o
);
  localparam int ROOT_W = WIDTH / 2;
  localparam int LAT_W  = $clog2(ROOT_W + 2) + 1;

  logic [WIDTH-1:0] cap_q;
  logic [LAT_W-1:0] lat_q;
  logic [WIDTH:0]   sq_lo, sq_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      lat_q <= '0;
    end else if (start_i && !busy_o) begin
      cap_q <= radicand_i;
      lat_q <= '0;
    end else if (busy_o) begin
      lat_q <= lat_q + LAT_W'(1);
    end
  end

  always_comb begin
    sq_lo = (WIDTH+1)'(root_o) * (WIDTH+1)'(root_o);
    sq_hi = ((WIDTH+1)'(root_o) + (WIDTH+1)'(1)) * ((WIDTH+1)'(root_o) + (WIDTH+1)'(1));
  end

  p_capture_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lat_q == LAT_W'(ROOT_W)));

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_busy_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);

  p_root_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sq_lo <= (WIDTH+1)'(cap_q)) && ((WIDTH+1)'(cap_q) < sq_hi));

  p_remainder_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((WIDTH+1)'(rem_o) == (WIDTH+1)'(cap_q) - sq_lo));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(root_o) && $stable(rem_o)));
endmodule

bind isqrt_seq isqrt_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .radicand_i (radicand_i),
  .busy_o     (busy_o),
  .valid_o    (valid_o),
  .root_o     (root_o),
  .rem_o      (rem_o)
);

// File: tb/tb_isqrt_seq.sv
module tb_isqrt_seq;
  localparam int WIDTH  = 8;
  localparam int ROOT_W = WIDTH / 2;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic [WIDTH-1:0]   radicand_i = '0;
  logic               busy_o, valid_o;
  logic [ROOT_W-1:0]  root_o;
  logic [ROOT_W:0]    rem_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  isqrt_seq #(.WIDTH(WIDTH)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .radicand_i (radicand_i),
    .busy_o (busy_o), .valid_o (valid_o), .root_o (root_o), .rem_o (rem_o)
  );

  function automatic int ref_root(input int x);
    int r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int x, input bit spoil, input int other);
    int k = 0;
    int er = ref_root(x);
    int r_keep, m_keep;
    while (busy_o) @(negedge clk);
    start_i = 1'b1; radicand_i = WIDTH'(x);
    @(negedge clk);
    start_i = 1'b0; radicand_i = WIDTH'($urandom);
    check(busy_o == 1'b1, "R2", "busy after capture", int'(busy_o), 1);
    while (!valid_o && k < 50) begin
      @(negedge clk);
      k++;
      if (spoil && k == 1) begin start_i = 1'b1; radicand_i = WIDTH'(other); end
      if (spoil && k == 2) start_i = 1'b0;
    end
    check(k == ROOT_W, "R4", "latency", k, ROOT_W);
    check(busy_o == 1'b0, "R4", "busy at valid", int'(busy_o), 0);
    check(int'(root_o) == er, spoil ? "R3" : "R5", "root", int'(root_o), er);
    check(int'(rem_o) == x - er * er, spoil ? "R3" : "R6", "remainder",
          int'(rem_o), x - er * er);
    r_keep = int'(root_o); m_keep = int'(rem_o);
    @(negedge clk);
    check(valid_o == 1'b0, "R4", "pulse width", int'(valid_o), 0);
    check(int'(root_o) == r_keep && int'(rem_o) == m_keep, "R7", "hold root",
          int'(root_o), r_keep);
    if (spoil) begin
      for (int i = 0; i < ROOT_W + 2; i++) begin
        @(negedge clk);
        check(!valid_o && !busy_o, "R3", "no second result", int'(valid_o), 0);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd7);
    repeat (3) @(negedge clk);
    check(!busy_o && !valid_o && root_o == '0 && rem_o == '0, "R1", "in reset",
          int'(root_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !valid_o && root_o == '0 && rem_o == '0, "R1", "after reset",
          int'(rem_o), 0);

    // R8 corners
    run_op(0, 1'b0, 0);
    check(root_o == '0 && rem_o == '0, "R8", "zero radicand", int'(root_o), 0);
    run_op(255, 1'b0, 0);
    check(int'(root_o) == 15, "R8", "root of 255", int'(root_o), 15);
    check(int'(rem_o) == 30, "R8", "remainder of 255", int'(rem_o), 30);

    // R7 hold during idle with moving operand
    for (int i = 0; i < 4; i++) begin
      radicand_i = WIDTH'($urandom);
      @(negedge clk);
      check(int'(root_o) == 15 && int'(rem_o) == 30, "R7", "idle hold",
            int'(root_o), 15);
    end

    // R5 R6 exhaustive sweep
    for (int x = 0; x < (1 << WIDTH); x++) run_op(x, 1'b0, 0);

    // random, with ignored mid-operation requests (R3)
    for (int i = 0; i < 200; i++) begin
      int x = int'($urandom % (1 << WIDTH));
      int o = int'($urandom % (1 << WIDTH));
      run_op(x, ($urandom % 2) == 1, o);
      repeat ($urandom % 3) @(negedge clk);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule